// File: doc/BRIEF.md
# Programmable Timebase Divider Timer

This block divides the system clock by a ratio held in a 16-bit register and raises a sticky interrupt flag once per period. Software writes the ratio, selects the counting direction and the reload policy through a small write-only register port, then issues a load command that copies the ratio into the working counter. While the run bit is set the counter moves by one every clock.

In the downward direction the period ends when the counter reaches zero, so a ratio of N gives N clocks per period. In the upward direction the period ends on the wrap from the all-ones value to zero, so software preloads the two's complement (65536 minus N) to obtain N clocks. With automatic reload the counter takes the ratio again at the end of each period. Without it the counter parks at zero and stays idle until software issues another load.

Top module: `tick_divider`

## Requirements
- R1: After reset `irq` is 0, `count_o` is 0 and the counter is idle; setting the run bit without a load command leaves both unchanged.
- R2: Writes are decoded on `wr_addr`: 0 holds the ratio, 1 holds control (bit 0 run, bit 1 count upward, bit 2 automatic reload), 2 is a command (bit 0 load, bit 1 clear flag). A write to address 3 changes neither the ratio nor the control bits.
- R3: A load command puts the ratio on `count_o` at the edge that accepts it and makes the counter active; the counter does not move on that edge.
- R4: Counting downward from a loaded ratio N (1 to 65535), `irq` rises at the N-th edge after the edge that accepted the load.
- R5: Counting upward, the period ends at the wrap from 0xFFFF to 0x0000; a preload of 65536 − N raises `irq` N edges after the load edge.
- R6: A ratio of zero counting downward gives a period of 65536 edges; the counter shows 0xFFFF one edge after the load.
- R7: With automatic reload the counter takes the ratio at the end of each period and the next period ends N edges later.
- R8: Without automatic reload the counter shows 0 after the period end and stays idle, with no further flag, until a new load command.
- R9: While the run bit is 0 the counter holds its value; after the run bit is set, the period ends N edges after the edge that accepted the control write.
- R10: The flag stays high until a clear command; a period end sets it even when it is already set, and a period end on the same edge as a clear leaves it set.
- R11: A ratio written while the counter is running does not change the current period; it applies from the next reload.
- R12: With a ratio of 40000 and automatic reload (a 4 MHz clock giving 10 ms), consecutive period ends are 40000 edges apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, counter step rate |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 2 | Register address for the write |
| wr_data | input | 16 | Write data |
| count_o | output | 16 | Present value of the working counter |
| irq | output | 1 | Sticky interrupt flag |

## Verification
Every write is accepted on the rising edge after it is driven, a load shows on `count_o` at that same edge, and the counter then moves once per edge, so a ratio N sets `irq` exactly N edges after the accepting edge (65536 for a zero ratio counting downward). The bench counts rising edges, computes the due edge of every flag rise from the write cycle and the ratio, and queues it; a monitor sampling at the falling edge matches each observed rise of `irq` with the head of the queue. Counter values and flag levels are sampled at the falling edge after the edge that is expected to change them, including the clear that lands on the same edge as a period end.

// File: rtl/tick_divider_pkg.sv
// Shared definitions for the timebase divider: register addresses,
// control bit layout and command bit positions.
package tick_divider_pkg;

    typedef enum logic [1:0] {
        REG_RATIO = 2'd0,
        REG_CTRL  = 2'd1,
        REG_CMD   = 2'd2,
        REG_SPARE = 2'd3
    } reg_addr_e;

    // Control register, bit 0 run, bit 1 count upward, bit 2 automatic reload
    typedef struct packed {
        logic auto_reload;
        logic count_up;
        logic run;
    } ctrl_t;

    localparam int unsigned CTRL_W        = 3;
    localparam int unsigned CMD_LOAD_BIT  = 0;
    localparam int unsigned CMD_CLEAR_BIT = 1;

endpackage

// File: rtl/tick_divider_regs.sv
// Register decode for the divider.
// Holds the ratio and the control bits, and turns command writes into
// single-cycle load and clear strobes. Assumes W >= CTRL_W.
module tick_divider_regs
    import tick_divider_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] ratio_q,
    output ctrl_t        ctrl_q,
    output logic         load_p,
    output logic         clear_p
);

    logic hit_ratio;
    logic hit_ctrl;
    logic hit_cmd;

    // Address decode of the incoming write
    always_comb begin
        hit_ratio = wr_en && (wr_addr == REG_RATIO);
        hit_ctrl  = wr_en && (wr_addr == REG_CTRL);
        hit_cmd   = wr_en && (wr_addr == REG_CMD);
    end

    // Command strobes last exactly the write cycle
    always_comb begin
        load_p  = hit_cmd && wr_data[CMD_LOAD_BIT];
        clear_p = hit_cmd && wr_data[CMD_CLEAR_BIT];
    end

    // Ratio storage, read by the counter only at load or reload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ratio_q <= '0;
        end else if (hit_ratio) begin
            ratio_q <= wr_data;
        end
    end

    // Control storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (hit_ctrl) begin
            ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
        end
    end

    // R2: the spare address touches no stored state
    a_r2_spare_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == REG_SPARE) |=> ($stable(ratio_q) && $stable(ctrl_q)));

endmodule

// File: rtl/tick_divider_count.sv
// Working counter of the divider.
// Counts down to zero or up to the wrap, flags the end of each period
// and then reloads the ratio or parks at zero. A load command always
// wins over a period end in the same cycle. Assumes W >= 2.
module tick_divider_count
    import tick_divider_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ratio_i,
    input  ctrl_t        ctrl_i,
    input  logic         load_i,
    output logic [W-1:0] cnt_q,
    output logic         expire_o
);

    localparam logic [W-1:0] LAST_UP = '1;
    localparam logic [W-1:0] LAST_DN = W'(1);

    logic         idle_q;
    logic         step;
    logic         at_last;
    logic [W-1:0] cnt_next;

    // Counter advances only when running and armed by a load
    always_comb begin
        step = ctrl_i.run && !idle_q;
    end

    // Period end: the step that lands on zero, in either direction
    always_comb begin
        at_last  = ctrl_i.count_up ? (cnt_q == LAST_UP) : (cnt_q == LAST_DN);
        expire_o = step && at_last && !load_i;
    end

    // Next value of a plain step
    always_comb begin
        cnt_next = ctrl_i.count_up ? cnt_q + W'(1) : cnt_q - W'(1);
    end

    // Counter and idle state update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            idle_q <= 1'b1;
        end else if (load_i) begin
            cnt_q  <= ratio_i;
            idle_q <= 1'b0;
        end else if (expire_o) begin
            if (ctrl_i.auto_reload) begin
                cnt_q <= ratio_i;
            end else begin
                cnt_q  <= '0;
                idle_q <= 1'b1;
            end
        end else if (step) begin
            cnt_q <= cnt_next;
        end
    end

    // R3: a load shows the ratio and arms the counter
    a_r3_load_takes_ratio: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_q == $past(ratio_i)) && !idle_q);

    // R7: automatic reload restores the ratio at the period end
    a_r7_reload_on_expire: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && ctrl_i.auto_reload) |=> (cnt_q == $past(ratio_i)));

    // R8: one-shot period end parks the counter at zero
    a_r8_oneshot_parks: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && !ctrl_i.auto_reload) |=> (cnt_q == '0) && idle_q);

    // R8: an idle counter stays put until a load
    a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_q && !load_i) |=> ($stable(cnt_q) && idle_q));

    // R9: a stopped counter holds its value
    a_r9_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_i.run && !load_i) |=> $stable(cnt_q));

endmodule

// File: rtl/tick_divider_flag.sv
// Sticky interrupt flag of the divider.
// Set by a period end, cleared by a clear command; a period end in the
// same cycle as a clear keeps the flag set.
module tick_divider_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic expire_i,
    input  logic clear_i,
    output logic flag_q
);

    // Flag register with set priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (expire_i) begin
            flag_q <= 1'b1;
        end else if (clear_i) begin
            flag_q <= 1'b0;
        end
    end

    // R10: flag holds until cleared
    a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clear_i) |=> flag_q);

    // R10: every period end leaves the flag set
    a_r10_expire_sets: assert property (@(posedge clk) disable iff (!rst_n)
        expire_i |=> flag_q);

    // R10: a clear with no period end drops the flag
    a_r10_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && !expire_i) |=> !flag_q);

endmodule

// File: rtl/tick_divider.sv
// Programmable timebase divider, top level.
// Wires the register decode, the working counter and the sticky flag.
// Assumes one register write per cycle and a synchronous reset.
module tick_divider
    import tick_divider_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] count_o,
    output logic         irq
);

    logic [W-1:0] ratio_q;
    ctrl_t        ctrl_q;
    logic         load_p;
    logic         clear_p;
    logic         expire;

    tick_divider_regs #(.W(W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ratio_q (ratio_q),
        .ctrl_q  (ctrl_q),
        .load_p  (load_p),
        .clear_p (clear_p)
    );

    tick_divider_count #(.W(W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .ratio_i  (ratio_q),
        .ctrl_i   (ctrl_q),
        .load_i   (load_p),
        .cnt_q    (count_o),
        .expire_o (expire)
    );

    tick_divider_flag u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .expire_i (expire),
        .clear_i  (clear_p),
        .flag_q   (irq)
    );

    // R1: reset leaves the counter and flag at zero
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (count_o == '0) && !irq);

endmodule

// File: tb/test_tick_divider.sv
`timescale 1ns/1ps
module test_tick_divider;
    import tick_divider_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [1:0]  wr_addr;
    logic [15:0] wr_data;
    logic [15:0] count_o;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int t0;

    int    due_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    tick_divider #(.W(16)) i_tick_divider (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .count_o (count_o),
        .irq     (irq)
    );

    task automatic check_eq(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_addr = 2'd0;
        wr_data = 16'd0;
    endtask

    task automatic wait_until(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic expect_rise(input int due, input string tag);
        due_q.push_back(due);
        tag_q.push_back(tag);
    endtask

    task automatic clr();
        wr(REG_CMD, 16'h0002);
    endtask

    // Monitor: match every rise of irq with the head of the scoreboard
    logic irq_seen = 1'b0;
    always @(negedge clk) begin
        int    due_v;
        string tag_v;
        if (rst_n === 1'b1) begin
            if (irq && !irq_seen) begin
                if (due_q.size() == 0) begin
                    n_checks++;
                    n_fail++;
                    $display("FAIL R10: unexpected irq rise at cycle %0d, expected none", cyc);
                end else begin
                    due_v = due_q.pop_front();
                    tag_v = tag_q.pop_front();
                    check_eq(tag_v, cyc, due_v);
                end
            end
            irq_seen = irq;
        end
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = 2'd0; wr_data = 16'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1", irq, 0);
        check_eq("R1", count_o, 0);

        // R1: run without load stays idle; R2: spare write ignored
        wr(REG_CTRL, 16'h0001);
        wr(REG_RATIO, 16'd5);
        wr(REG_SPARE, 16'h0009);
        repeat (20) @(negedge clk);
        check_eq("R1", count_o, 0);
        check_eq("R1", irq, 0);

        // R3/R4: down count of 5, one-shot
        t0 = cyc;
        wr(REG_CMD, 16'h0001);
        check_eq("R3", count_o, 5);
        expect_rise(t0 + 6, "R4");
        @(negedge clk);
        check_eq("R2", count_o, 4);
        wait_until(t0 + 10);
        check_eq("R8", count_o, 0);
        clr();
        repeat (30) @(negedge clk);
        check_eq("R8", irq, 0);
        check_eq("R8", count_o, 0);

        // R9: stopped counter holds, then runs
        wr(REG_CTRL, 16'h0000);
        wr(REG_RATIO, 16'd100);
        wr(REG_CMD, 16'h0001);
        repeat (20) @(negedge clk);
        check_eq("R9", count_o, 100);
        t0 = cyc;
        wr(REG_CTRL, 16'h0001);
        expect_rise(t0 + 101, "R9");
        wait_until(t0 + 105);
        clr();

        // R5: up count with complement preload for 300
        wr(REG_CTRL, 16'h0003);
        wr(REG_RATIO, 16'd65236);
        t0 = cyc;
        wr(REG_CMD, 16'h0001);
        check_eq("R5", count_o, 65236);
        expect_rise(t0 + 301, "R5");
        wait_until(t0 + 305);
        check_eq("R5", count_o, 0);
        clr();

        // R10: sticky flag, re-set, clear on the period-end edge
        wr(REG_CTRL, 16'h0005);
        wr(REG_RATIO, 16'd20);
        t0 = cyc;
        wr(REG_CMD, 16'h0001);
        expect_rise(t0 + 21, "R10");
        wait_until(t0 + 45);
        check_eq("R10", irq, 1);
        wait_until(t0 + 60);
        clr();
        check_eq("R10", irq, 1);
        clr();
        check_eq("R10", irq, 0);
        expect_rise(t0 + 81, "R10");
        wait_until(t0 + 85);
        wr(REG_CTRL, 16'h0004);
        clr();

        // R11: ratio rewritten mid-period applies at the next reload
        wr(REG_CTRL, 16'h0005);
        wr(REG_RATIO, 16'd60);
        t0 = cyc;
        wr(REG_CMD, 16'h0001);
        expect_rise(t0 + 61, "R11");
        wait_until(t0 + 10);
        wr(REG_RATIO, 16'd25);
        wait_until(t0 + 20);
        check_eq("R11", count_o, 41);
        wait_until(t0 + 65);
        clr();
        expect_rise(t0 + 86, "R11");
        wait_until(t0 + 90);
        wr(REG_CTRL, 16'h0004);
        clr();

        // R12/R7: 40000 ratio, auto-reload, two periods
        wr(REG_RATIO, 16'd40000);
        wr(REG_CTRL, 16'h0005);
        t0 = cyc;
        wr(REG_CMD, 16'h0001);
        expect_rise(t0 + 40001, "R12");
        expect_rise(t0 + 80001, "R7");
        wait_until(t0 + 40005);
        clr();
        wait_until(t0 + 80005);
        wr(REG_CTRL, 16'h0004);
        clr();

        // R6: zero ratio counting down lasts 65536 edges
        wr(REG_CTRL, 16'h0001);
        wr(REG_RATIO, 16'd0);
        t0 = cyc;
        wr(REG_CMD, 16'h0001);
        @(negedge clk);
        check_eq("R6", count_o, 65535);
        expect_rise(t0 + 65537, "R6");
        wait_until(t0 + 65540);
        clr();

        repeat (5) @(negedge clk);
        while (due_q.size() != 0) begin
            n_checks++;
            n_fail++;
            $display("FAIL %s: actual no irq rise expected rise at cycle %0d",
                     tag_q.pop_front(), due_q.pop_front());
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule